// File: doc/BRIEF.md
# Double-Buffered Serial Converter Input Front End

This block is the digital front end of a 12-bit voltage-output converter. A three-wire serial port (data, serial clock, active-low select) fills an input shift register. The most significant bit arrives first, and the register moves one bit on each rising serial clock while the port is selected. A second register, the output holding register, drives the converter code. While the active-low load strobe is low, the holding register is transparent and follows the shift register. When the strobe returns high, the holding register keeps the value it had. Because the two registers are separate, a new word can be preloaded while the present output code stays unchanged.

An active-low clear forces the holding register to zero at once, with no clock needed. Select gates only the shifting. Loading works whether or not the port is selected. All serial pins are sampled in one system clock domain through a synchronizer of `SYNC_STAGES` flops. Edges are found from the synchronized levels. The block also drives the ideal output level in half-millivolt steps and a one-cycle flag for a forbidden case: a serial clock edge that shifts data while the load strobe is low.

Top module: `dac_serial_frontend`

## Requirements
- R1: After the system reset, `code_o` and `out_hmv_o` are 0 and `proto_err_o` is 0.
- R2: Each rising `sclk_i` seen while `cs_ni` is low shifts `sdi_i` into bit 0 of the shift register and moves the other bits one place up. A 12-bit word therefore lands with its first-sent bit in bit 11. A shorter burst of n bits leaves those bits in the low n positions.
- R3: While `cs_ni` is high, `sclk_i` edges leave the shift register unchanged.
- R4: While `ld_ni` is low (and clear is high), `code_o` equals the shift register contents, with the synchronizer latency.
- R5: While `ld_ni` is high, `code_o` holds its value. Shifting a new word does not change it. On the rising edge of `ld_ni`, the value already showing is kept.
- R6: The load strobe acts whether `cs_ni` is high or low.
- R7: While `clr_ni` is low, `code_o` is 0 immediately, without any clock edge and whatever the state of `ld_ni`. If the clear is released with `ld_ni` high, the code stays 0.
- R8: The clear does not alter the shift register. A load after the clear shows the word that was shifted in before it.
- R9: `proto_err_o` is high for exactly one cycle for each shifting serial clock edge that occurs while `ld_ni` is low, and is low otherwise.
- R10: `out_hmv_o` equals `code_o` in half-millivolt units. Code 0x7FF gives 2047 (1.0235 V), 0x800 gives 2048 (1.0240 V), and 0xFFF gives 4095 (2.0475 V).
- R11: Each pin change is seen at the outputs exactly `SYNC_STAGES`+1 system clocks after it is sampled. This holds cycle by cycle against a behavioural model.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| sclk_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data pin |
| cs_ni | input | 1 | Active-low serial select |
| ld_ni | input | 1 | Active-low load strobe (level transparent) |
| clr_ni | input | 1 | Active-low asynchronous clear of the holding register |
| code_o | output | CODE_W | Holding register code |
| out_hmv_o | output | CODE_W | Ideal output level in 0.5 mV units |
| proto_err_o | output | 1 | One-cycle pulse when data shifts while loading |

## Verification
Two situations are hardest to reach from the pins.

The first is the clear arriving while the load strobe is already low. Here the asynchronous clear must win over the transparent path, and releasing the clear must reopen that path. The stimulus lowers the load strobe, asserts the clear mid-cycle, checks a zero code before the next clock edge, then releases the clear under both strobe levels.

The second is the shifted-while-loading violation. It needs a serial edge that passes the select gate during the transparent window. Directed bursts and random mixes of partial shifts, select toggles and clears are checked against a clock-accurate model.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    // bit positions inside the synchronized pin vector
    localparam int PIN_SCLK = 0;
    localparam int PIN_CSN  = 1;
    localparam int PIN_LDN  = 2;
    localparam int PIN_SDI  = 3;
    localparam int PIN_W    = 4;
    // idle pin levels: clock low, deselected, load high, data low
    localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0110;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_t;

    localparam sync_t SYNC_RST = {STAGES{RST_VAL}};

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = pins_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= SYNC_RST;
        else         st_q <= st_d;
    end

    assign lvl_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/sfe_shift.sv
module sfe_shift #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         shift_en_i,
    input  logic         sdi_i,
    output logic [W-1:0] data_d_o,
    output logic [W-1:0] data_q_o
);
    typedef struct packed {
        logic [W-1:0] data;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en_i) st_d.data = {st_q.data[W-2:0], sdi_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign data_d_o = st_d.data;
    assign data_q_o = st_q.data;

    AST_SHIFT_MSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_en_i |=> (data_q_o[0] == $past(sdi_i)) && (data_q_o[W-1:1] == $past(data_q_o[W-2:0]))); // R2
    AST_NO_SHIFT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_en_i |=> $stable(data_q_o)); // R3
endmodule

// File: rtl/sfe_hold.sv
module sfe_hold #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_ni,
    input  logic         load_low_i,
    input  logic         load_rise_i,
    input  logic [W-1:0] shift_next_i,
    input  logic [W-1:0] shift_cur_i,
    output logic [W-1:0] code_o
);
    typedef struct packed {
        logic [W-1:0] code;
    } hold_t;

    hold_t st_d, st_q;
    logic  arst_n;

    assign arst_n = rst_ni & clr_ni;

    always_comb begin
        st_d = st_q;
        if (load_low_i)       st_d.code = shift_next_i;
        else if (load_rise_i) st_d.code = shift_cur_i;
    end

    always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign code_o = st_q.code;

    AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_ni |-> (code_o == '0)); // R7
    AST_LATCHED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
        (!load_low_i && !load_rise_i) |=> $stable(code_o)); // R5
endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend
    import sfe_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              cs_ni,
    input  logic              ld_ni,
    input  logic              clr_ni,
    output logic [CODE_W-1:0] code_o,
    output logic [CODE_W-1:0] out_hmv_o,
    output logic              proto_err_o
);
    typedef struct packed {
        logic prev_sclk;
        logic prev_ldn;
        logic err;
    } top_t;

    localparam top_t TOP_RST = '{prev_sclk: 1'b0, prev_ldn: 1'b1, err: 1'b0};

    logic [PIN_W-1:0]  pins, lvl;
    logic              sclk_rise, load_low, load_rise, shift_en;
    logic [CODE_W-1:0] shift_next, shift_cur;
    top_t              st_d, st_q;

    assign pins = {sdi_i, ld_ni, cs_ni, sclk_i};

    sfe_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pins_i(pins),
        .lvl_o (lvl)
    );

    assign sclk_rise = lvl[PIN_SCLK] & ~st_q.prev_sclk;
    assign load_rise = lvl[PIN_LDN]  & ~st_q.prev_ldn;
    assign load_low  = ~lvl[PIN_LDN];
    assign shift_en  = sclk_rise & ~lvl[PIN_CSN];

    always_comb begin
        st_d           = st_q;
        st_d.prev_sclk = lvl[PIN_SCLK];
        st_d.prev_ldn  = lvl[PIN_LDN];
        st_d.err       = shift_en & load_low;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= TOP_RST;
        else         st_q <= st_d;
    end

    sfe_shift #(.W(CODE_W)) u_shift (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .shift_en_i(shift_en),
        .sdi_i     (lvl[PIN_SDI]),
        .data_d_o  (shift_next),
        .data_q_o  (shift_cur)
    );

    sfe_hold #(.W(CODE_W)) u_hold (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_ni      (clr_ni),
        .load_low_i  (load_low),
        .load_rise_i (load_rise),
        .shift_next_i(shift_next),
        .shift_cur_i (shift_cur),
        .code_o      (code_o)
    );

    assign out_hmv_o   = code_o;
    assign proto_err_o = st_q.err;

    AST_ERR_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        proto_err_o |=> !proto_err_o); // R9
    AST_ERR_NEEDS_LOAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        proto_err_o |-> $past(load_low)); // R9
endmodule

// File: tb/dac_serial_frontend_tb.sv
module dac_serial_frontend_tb;
    localparam int W = 12;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, ld_n = 1'b1, clr_n = 1'b0;
    logic [W-1:0] code, hmv;
    logic perr;

    int checks = 0;
    int errors = 0;
    int viol_seen = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dac_serial_frontend #(.CODE_W(W), .SYNC_STAGES(S)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .cs_ni(cs_n),
        .ld_ni(ld_n), .clr_ni(clr_n), .code_o(code), .out_hmv_o(hmv), .proto_err_o(perr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: history of sampled pins {sdi, ld_n, cs_n, sclk}
    logic [3:0] hist [0:S+1];
    logic [W-1:0] m_shift = '0, m_hold = '0;
    logic m_err = 1'b0;

    always @(posedge clk) begin
        logic [3:0] cur, prv;
        logic sh;
        logic [W-1:0] nxt;
        if (!rst_n) begin
            for (int i = 0; i <= S + 1; i++) hist[i] = 4'b0110;
            m_shift = '0; m_hold = '0; m_err = 1'b0;
        end else begin
            for (int i = S + 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = {sdi, ld_n, cs_n, sclk};
            cur = hist[S];
            prv = hist[S+1];
            sh  = cur[0] & ~prv[0] & ~cur[1];
            nxt = sh ? {m_shift[W-2:0], cur[3]} : m_shift;
            m_err = sh & ~cur[2];
            if (!clr_n)                m_hold = '0;
            else if (!cur[2])          m_hold = nxt;
            else if (cur[2] & ~prv[2]) m_hold = m_shift;
            m_shift = nxt;
        end
        #2;
        if (rst_n && !done) begin
            chk("R11 code vs model", code, m_hold);
            chk("R10 level vs model", hmv, m_hold);
            chk("R9 flag vs model", perr, m_err);
            if (perr) viol_seen++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [W-1:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = w[i];
            wait_cyc(2);
            sclk = 1'b1;
            wait_cyc(3);
            sclk = 1'b0;
            wait_cyc(3);
        end
        wait_cyc(S + 3);
    endtask

    task automatic load_pulse();
        ld_n = 1'b0;
        wait_cyc(S + 3);
        ld_n = 1'b1;
        wait_cyc(S + 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        clr_n = 1'b1;
        wait_cyc(S + 3);
        chk("R1 reset code", code, 0);
        chk("R1 reset level", hmv, 0);
        chk("R1 reset flag", perr, 0);

        cs_n = 1'b0;
        shift_bits(12'hA5C, W);
        chk("R5 preload keeps output", code, 0);
        load_pulse();
        chk("R2 msb-first word", code, 12'hA5C);
        chk("R10 level follows code", hmv, 12'hA5C);

        shift_bits(12'h3C3, W);
        ld_n = 1'b0;
        wait_cyc(S + 3);
        chk("R4 transparent while load low", code, 12'h3C3);
        ld_n = 1'b1;
        wait_cyc(S + 3);
        shift_bits(12'h111, W);
        chk("R5 latched after load rise", code, 12'h3C3);

        cs_n = 1'b1;
        load_pulse();
        chk("R6 load while deselected", code, 12'h111);
        shift_bits(12'hEEE, W);
        load_pulse();
        chk("R3 no shift while deselected", code, 12'h111);

        cs_n = 1'b0;
        shift_bits(12'h800, W);
        load_pulse();
        chk("R10 midscale 0x800", hmv, 2048);
        clr_n = 1'b0;
        #1;
        chk("R7 async clear before edge", code, 0);
        wait_cyc(1);
        ld_n = 1'b0;
        wait_cyc(S + 3);
        chk("R7 clear wins over load low", code, 0);
        ld_n = 1'b1;
        wait_cyc(S + 3);
        clr_n = 1'b1;
        wait_cyc(S + 3);
        chk("R7 stays zero after release", code, 0);
        load_pulse();
        chk("R8 shift register kept by clear", code, 12'h800);

        shift_bits(12'h7FF, W);
        load_pulse();
        chk("R10 code 0x7FF", hmv, 2047);
        shift_bits(12'hFFF, W);
        load_pulse();
        chk("R10 full scale", hmv, 4095);
        shift_bits(12'h000, W);
        load_pulse();
        chk("R10 zero scale", hmv, 0);
        shift_bits(12'h01F, 5);
        load_pulse();
        chk("R2 partial burst", code, 12'h01F);

        chk("R9 no flag in legal traffic", viol_seen, 0);
        ld_n = 1'b0;
        wait_cyc(S + 3);
        shift_bits(12'h001, 1);
        ld_n = 1'b1;
        wait_cyc(S + 3);
        chk("R9 one pulse per violation", viol_seen, 1);
        chk("R4 shifted bit shows while low", code, 12'h03F);

        for (int k = 0; k < 20; k++) begin
            logic [W-1:0] w;
            w = W'($urandom);
            shift_bits(w, W);
            load_pulse();
            chk("R2 random word", code, w);
        end

        for (int k = 0; k < 12; k++) begin
            cs_n = 1'($urandom);
            shift_bits(W'($urandom), 1 + int'($urandom % W));
            if ($urandom % 3 == 0) begin
                clr_n = 1'b0;
                wait_cyc(2);
                clr_n = 1'b1;
                wait_cyc(2);
            end
            load_pulse();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule